// File: doc/BRIEF.md
# Gigabit Ethernet Receive Rate Match Buffer

This block is a receive-side elastic buffer for a decoded Gigabit Ethernet symbol stream. Each symbol (8 data bits plus a control flag) is written on the recovered clock, one symbol per cycle, and read on the local clock, one symbol per cycle. The two clocks are nominally equal but may differ slightly. Write and read pointers cross between the domains as Gray codes through two-flop synchronizers.

The buffer absorbs the frequency offset by editing idle traffic only. The unit of editing is a complete /I2/ idle ordered set: the control symbol K28.5 followed by the data symbol D16.2. When the buffer runs high, the write side drops such a pair. When it runs low, the read side repeats one right after an /I2/ it has just sent. A packet symbol is never added or removed, and an ordered set is never split.

Overflow and underflow are not repaired. Each raises a sticky flag that stays set until the external reset is applied. After reset the read side holds back its output until the buffer has filled to a priming level.

Top module: `gige_rate_match`

## Requirements
- R1: Apart from whole /I2/ pairs that are added or removed, the valid output symbol sequence equals the written input sequence in order. A symbol is 9 bits, {k, data}.
- R2: The write side removes symbols only as a K28.5 (k=1, data 8'hBC) directly followed by D16.2 (k=0, data 8'h50). Both symbols are dropped, and only while the write-side fill exceeds HI_MARK. wr_del_o pulses for one write cycle per removed pair.
- R3: An insertion starts only when the read-side fill is below LO_MARK and the previous two outputs were K28.5 then D16.2. The inserted symbols are K28.5 then D16.2.
- R4: rd_ins_o is high for exactly the two inserted symbols of each inserted pair, and no input symbol is output between them.
- R5: After reset rd_valid_o stays low until the read-side fill reaches PRIME_MARK, and then rises.
- R6: A write attempted while the buffer holds DEPTH entries sets wr_full_o. The flag stays set and no further entries are written until rst_ni is asserted.
- R7: A read needed while the buffer is empty sets rd_empty_o. The flag stays set, rd_valid_o stays low and the read pointer stays frozen until rst_ni is asserted.
- R8: While rst_ni is low, and in the first cycle after it is released, rd_valid_o, rd_ins_o, rd_empty_o, wr_del_o and wr_full_o are low.
- R9: With the write clock about 1% faster and idle gaps in the stream, removals keep the buffer from overflowing.
- R10: With the write clock about 1% slower and idle gaps in the stream, insertions keep the buffer from underflowing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Recovered (write) clock |
| rd_clk_i | input | 1 | Local (read) clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| wr_k_i | input | 1 | Control flag of the incoming symbol |
| wr_d_i | input | 8 | Incoming symbol value |
| rd_k_o | output | 1 | Control flag of the output symbol |
| rd_d_o | output | 8 | Output symbol value |
| rd_valid_o | output | 1 | Output symbol is meaningful |
| rd_ins_o | output | 1 | Output symbol belongs to an inserted /I2/ |
| wr_del_o | output | 1 | An /I2/ pair was removed (write domain pulse) |
| wr_full_o | output | 1 | Sticky overflow flag (write domain) |
| rd_empty_o | output | 1 | Sticky underflow flag (read domain) |

## Verification
The hardest situation to reach is the point where the fill level has drifted past a threshold at the exact moment an /I2/ pair is available for editing. Only then do insertions and removals happen. The bench runs the write clock 1% fast and then 1% slow over several thousand symbols of random packets separated by random idle gaps, so the fill wanders across both thresholds many times. The output is matched against the recorded input, allowing only whole /I2/ pairs to differ. Two further runs with idle-free data and the same clock offsets force a real overflow and a real underflow, to show that both flags stick.

// File: rtl/gige_rm_pkg.sv
`timescale 1ns/1ps
package gige_rm_pkg;
  localparam logic [7:0] K28_5 = 8'hBC;
  localparam logic [7:0] D16_2 = 8'h50;

  typedef struct packed {
    logic       k;
    logic [7:0] d;
  } sym_t;

  function automatic logic is_k285(sym_t s);
    return s.k && (s.d == K28_5);
  endfunction

  function automatic logic is_d162(sym_t s);
    return !s.k && (s.d == D16_2);
  endfunction
endpackage

// File: rtl/rm_gray_sync.sv
`timescale 1ns/1ps
// two-flop synchronizer for a Gray pointer, binary out
module rm_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_o[i] = ^s2_q[W-1:i];
  end
endmodule

// File: rtl/rm_mem.sv
`timescale 1ns/1ps
module rm_mem
  import gige_rm_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  sym_t          wdata_i,
  input  logic [AW-1:0] raddr_i,
  output sym_t          rdata_o
);
  sym_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rm_wr_ctl.sv
`timescale 1ns/1ps
module rm_wr_ctl
  import gige_rm_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int HI_MARK = 12,
  parameter int AW      = $clog2(DEPTH),
  parameter int PW      = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sym_t          sym_i,
  input  logic [PW-1:0] rptr_bin_i,
  output logic [PW-1:0] wptr_gray_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output sym_t          wr_data_o,
  output logic          del_o,
  output logic          full_o
);
  sym_t          hold_q;
  logic          hold_vld_q;
  logic [PW-1:0] wptr_q, wptr_nxt, wgray_q, fill;
  logic          del_hit, want_wr, ovf, full_q, del_q;

  assign fill    = wptr_q - rptr_bin_i;
  // pair is K28.5 in hold followed by D16.2 arriving now
  assign del_hit = hold_vld_q && is_k285(hold_q) && is_d162(sym_i) && (fill > PW'(HI_MARK));
  assign want_wr = hold_vld_q && !del_hit;
  assign ovf     = want_wr && !full_q && (fill == PW'(DEPTH));
  assign wr_en_o = want_wr && !full_q && !ovf;
  assign wptr_nxt = wptr_q + PW'(wr_en_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      wptr_q     <= '0;
      wgray_q    <= '0;
      full_q     <= 1'b0;
      del_q      <= 1'b0;
    end else begin
      hold_q     <= sym_i;
      hold_vld_q <= !del_hit;
      wptr_q     <= wptr_nxt;
      wgray_q    <= wptr_nxt ^ (wptr_nxt >> 1);
      full_q     <= full_q | ovf;
      del_q      <= del_hit;
    end
  end

  assign wptr_gray_o = wgray_q;
  assign wr_addr_o   = wptr_q[AW-1:0];
  assign wr_data_o   = hold_q;
  assign del_o       = del_q;
  assign full_o      = full_q;

  // R6: no pointer movement once overflow is flagged
  p_no_wr_after_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> $stable(wptr_gray_o));
  // R2: a removal consumes the pair, so removals cannot be adjacent
  p_del_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    del_o |=> !del_o);
endmodule

// File: rtl/rm_rd_ctl.sv
`timescale 1ns/1ps
module rm_rd_ctl
  import gige_rm_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int LO_MARK    = 4,
  parameter int PRIME_MARK = 8,
  parameter int AW         = $clog2(DEPTH),
  parameter int PW         = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] wptr_bin_i,
  input  sym_t          rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [PW-1:0] rptr_gray_o,
  output sym_t          sym_o,
  output logic          ins_o,
  output logic          valid_o,
  output logic          empty_o
);
  logic [PW-1:0] rptr_q, rptr_nxt, rgray_q, fill;
  logic          primed_q, empty_q, ins_ph_q, prev_k_q, ins_q, vld_q;
  sym_t          out_q;
  logic          active, i2_done, start_ins, do_rd, udf;

  assign fill      = wptr_bin_i - rptr_q;
  assign active    = primed_q && !empty_q;
  assign i2_done   = vld_q && prev_k_q && is_d162(out_q);
  assign start_ins = active && !ins_ph_q && i2_done && (fill < PW'(LO_MARK));
  assign do_rd     = active && !ins_ph_q && !start_ins && (fill != '0);
  assign udf       = active && !ins_ph_q && !start_ins && (fill == '0);
  assign rptr_nxt  = rptr_q + PW'(do_rd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q   <= '0;
      rgray_q  <= '0;
      primed_q <= 1'b0;
      empty_q  <= 1'b0;
      ins_ph_q <= 1'b0;
      prev_k_q <= 1'b0;
      ins_q    <= 1'b0;
      vld_q    <= 1'b0;
      out_q    <= '0;
    end else begin
      rptr_q  <= rptr_nxt;
      rgray_q <= rptr_nxt ^ (rptr_nxt >> 1);
      if (!primed_q && fill >= PW'(PRIME_MARK)) primed_q <= 1'b1;
      if (udf) empty_q <= 1'b1;
      vld_q <= active && !udf;
      if (ins_ph_q) begin
        out_q    <= sym_t'{k: 1'b0, d: D16_2};
        ins_q    <= 1'b1;
        ins_ph_q <= 1'b0;
        prev_k_q <= is_k285(out_q);
      end else if (start_ins) begin
        out_q    <= sym_t'{k: 1'b1, d: K28_5};
        ins_q    <= 1'b1;
        ins_ph_q <= 1'b1;
        prev_k_q <= is_k285(out_q);
      end else if (do_rd) begin
        out_q    <= rd_data_i;
        ins_q    <= 1'b0;
        prev_k_q <= is_k285(out_q);
      end else begin
        ins_q    <= 1'b0;
      end
    end
  end

  assign rd_addr_o   = rptr_q[AW-1:0];
  assign rptr_gray_o = rgray_q;
  assign sym_o       = out_q;
  assign ins_o       = ins_q;
  assign valid_o     = vld_q;
  assign empty_o     = empty_q;

  // R4: inserted K28.5 is always followed by inserted D16.2
  p_ins_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_o && sym_o.k) |=> (ins_o && !sym_o.k && sym_o.d == D16_2));
  // R3: an insertion run begins right after a D16.2 went out
  p_ins_after_i2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ins_o) |-> (!$past(sym_o.k) && $past(sym_o.d) == D16_2));
  // R7: underflow silences output and freezes the read pointer
  p_empty_no_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !valid_o);
  p_empty_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |=> $stable(rptr_gray_o));
endmodule

// File: rtl/gige_rate_match.sv
`timescale 1ns/1ps
module gige_rate_match
  import gige_rm_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int LO_MARK    = 4,
  parameter int HI_MARK    = 12,
  parameter int PRIME_MARK = 8
) (
  input  logic       wr_clk_i,
  input  logic       rd_clk_i,
  input  logic       rst_ni,
  input  logic       wr_k_i,
  input  logic [7:0] wr_d_i,
  output logic       rd_k_o,
  output logic [7:0] rd_d_o,
  output logic       rd_valid_o,
  output logic       rd_ins_o,
  output logic       wr_del_o,
  output logic       wr_full_o,
  output logic       rd_empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  sym_t          wr_sym, mem_wdata, mem_rdata, rd_sym;
  logic          mem_we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wbin_rd, rbin_wr;

  assign wr_sym = sym_t'{k: wr_k_i, d: wr_d_i};

  rm_wr_ctl #(.DEPTH(DEPTH), .HI_MARK(HI_MARK), .AW(AW), .PW(PW)) u_wr (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .sym_i(wr_sym), .rptr_bin_i(rbin_wr),
    .wptr_gray_o(wgray), .wr_en_o(mem_we), .wr_addr_o(waddr), .wr_data_o(mem_wdata),
    .del_o(wr_del_o), .full_o(wr_full_o)
  );

  rm_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i(wr_clk_i), .we_i(mem_we), .waddr_i(waddr), .wdata_i(mem_wdata),
    .raddr_i(raddr), .rdata_o(mem_rdata)
  );

  rm_gray_sync #(.W(PW)) u_sync_w2r (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .gray_i(wgray), .bin_o(wbin_rd)
  );

  rm_gray_sync #(.W(PW)) u_sync_r2w (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .gray_i(rgray), .bin_o(rbin_wr)
  );

  rm_rd_ctl #(.DEPTH(DEPTH), .LO_MARK(LO_MARK), .PRIME_MARK(PRIME_MARK), .AW(AW), .PW(PW)) u_rd (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .wptr_bin_i(wbin_rd), .rd_data_i(mem_rdata),
    .rd_addr_o(raddr), .rptr_gray_o(rgray), .sym_o(rd_sym), .ins_o(rd_ins_o),
    .valid_o(rd_valid_o), .empty_o(rd_empty_o)
  );

  assign rd_k_o = rd_sym.k;
  assign rd_d_o = rd_sym.d;
endmodule

// File: tb/gige_rate_match_test.sv
`timescale 1ns/1ps
module gige_rate_match_test;
  localparam logic [8:0] S_K285 = 9'h1BC;
  localparam logic [8:0] S_D162 = 9'h050;
  localparam logic [8:0] S_SOP  = 9'h1FB;
  localparam logic [8:0] S_EOP  = 9'h1FD;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic wr_k = 0;
  logic [7:0] wr_d = 0;
  logic rd_k, rd_valid, rd_ins, wr_del, wr_full, rd_empty;
  logic [7:0] rd_d;
  real wr_half = 1.98;

  always #2.0 rd_clk = ~rd_clk;
  always #(wr_half) wr_clk = ~wr_clk;

  gige_rate_match uut (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_n),
    .wr_k_i(wr_k), .wr_d_i(wr_d),
    .rd_k_o(rd_k), .rd_d_o(rd_d), .rd_valid_o(rd_valid), .rd_ins_o(rd_ins),
    .wr_del_o(wr_del), .wr_full_o(wr_full), .rd_empty_o(rd_empty)
  );

  int n_chk = 0, n_bad = 0;
  logic [8:0] exp_mem [0:32767];
  int wi, ri, ins_cnt, del_cnt, ins_ph;
  int id_left, pk_left, pk_tot;
  bit id_half, wr_run, chk_en, idle_rich;
  logic [8:0] o1, o2;

  task automatic chk(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      if (n_bad < 40) $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stream generator: idle /I2/ gaps and even-length packets, or raw data
  always @(negedge wr_clk) begin
    logic [8:0] s;
    if (wr_run && rst_n) begin
      if (!idle_rich) s = {1'b0, 8'($urandom)};
      else if (id_half) begin
        s = S_D162; id_half = 0;
        if (id_left == 0) begin pk_left = 2 * (3 + int'($urandom % 8)); pk_tot = pk_left; end
      end else if (id_left > 0) begin
        s = S_K285; id_half = 1; id_left--;
      end else begin
        if (pk_left == pk_tot) s = S_SOP;
        else if (pk_left == 1) s = S_EOP;
        else s = {1'b0, 8'($urandom)};
        pk_left--;
        if (pk_left == 0) id_left = 2 + int'($urandom % 4);
      end
      {wr_k, wr_d} = s;
      if (wi < 32768) exp_mem[wi] = s;
      wi++;
    end
  end

  always @(negedge wr_clk) if (rst_n && wr_del) del_cnt++;

  // output checker
  always @(negedge rd_clk) begin
    logic [8:0] o;
    if (chk_en && rd_valid) begin
      o = {rd_k, rd_d};
      if (rd_ins) begin
        if (ins_ph == 0) begin
          chk(o == S_K285 && o1 == S_D162 && o2 == S_K285, "R3 insert after /I2/", o, S_K285);
          ins_ph = 1; ins_cnt++;
        end else begin
          chk(o == S_D162, "R4 inserted pair second half", o, S_D162);
          ins_ph = 0;
        end
      end else begin
        chk(ins_ph == 0, "R4 inserted pair split", o, S_D162);
        ins_ph = 0;
        // R2: only whole K28.5/D16.2 pairs may be missing
        while (ri + 1 < wi && ri + 1 < 32768 && o != exp_mem[ri] &&
               exp_mem[ri] == S_K285 && exp_mem[ri+1] == S_D162) ri += 2;
        if (ri < wi && ri < 32768) begin
          chk(o == exp_mem[ri], "R1 stream order", o, exp_mem[ri]);
          ri++;
        end else chk(0, "R1 output ahead of input", o, 9'h0);
      end
      o2 = o1; o1 = o;
    end
  end

  task automatic start_phase(input real half, input bit rich);
    rst_n = 0; chk_en = 0; wr_run = 0;
    repeat (4) @(posedge rd_clk);
    wr_half = half; idle_rich = rich;
    wi = 0; ri = 0; ins_cnt = 0; del_cnt = 0; ins_ph = 0; o1 = 0; o2 = 0;
    id_left = 4; id_half = 0; pk_left = 0; pk_tot = 0;
    @(negedge rd_clk);
    chk(!rd_valid && !rd_ins && !rd_empty && !wr_full && !wr_del, "R8 flags in reset",
        {4'b0, rd_valid, rd_ins, rd_empty, wr_full, wr_del}, 9'h0);
    wr_run = 1;
    @(posedge wr_clk); #0.3; rst_n = 1;
    @(negedge rd_clk);
    chk(!rd_valid && !rd_ins && !rd_empty && !wr_full && !wr_del, "R8 flags after release",
        {4'b0, rd_valid, rd_ins, rd_empty, wr_full, wr_del}, 9'h0);
    chk(!rd_valid, "R5 valid held before priming", {8'b0, rd_valid}, 9'h0);
    chk_en = 1;
    for (int i = 0; i < 60 && !rd_valid; i++) @(negedge rd_clk);
    chk(rd_valid, "R5 valid after priming", {8'b0, rd_valid}, 9'h1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #300000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    process::self().srandom(32'd7);
    void'($urandom(32'd1234));

    // write faster, idle-rich stream
    start_phase(1.98, 1);
    repeat (6000) @(negedge rd_clk);
    chk_en = 0;
    chk(del_cnt > 0, "R2 removals occurred", 9'(del_cnt), 9'h1);
    chk(!wr_full, "R9 no overflow when fast", {8'b0, wr_full}, 9'h0);
    chk(!rd_empty, "R9 no underflow when fast", {8'b0, rd_empty}, 9'h0);
    chk(ri > 5000, "R1 stream progressed", 9'(ri > 5000), 9'h1);

    // write slower, idle-rich stream
    start_phase(2.02, 1);
    repeat (6000) @(negedge rd_clk);
    chk_en = 0;
    chk(ins_cnt > 0, "R3 insertions occurred", 9'(ins_cnt), 9'h1);
    chk(!rd_empty, "R10 no underflow when slow", {8'b0, rd_empty}, 9'h0);
    chk(!wr_full, "R10 no overflow when slow", {8'b0, wr_full}, 9'h0);
    chk(del_cnt == 0, "R2 no removal when slow", 9'(del_cnt), 9'h0);

    // write faster, no idles: overflow must stick
    start_phase(1.98, 0);
    chk_en = 0;
    for (int i = 0; i < 4000 && !wr_full; i++) @(negedge wr_clk);
    chk(wr_full, "R6 overflow flagged", {8'b0, wr_full}, 9'h1);
    chk(del_cnt == 0, "R2 no removal without idles", 9'(del_cnt), 9'h0);
    repeat (3) @(negedge wr_clk);
    chk(wr_full, "R6 overflow sticky", {8'b0, wr_full}, 9'h1);

    // write slower, no idles: underflow must stick
    start_phase(2.02, 0);
    chk_en = 0;
    for (int i = 0; i < 4000 && !rd_empty; i++) @(negedge rd_clk);
    chk(rd_empty, "R7 underflow flagged", {8'b0, rd_empty}, 9'h1);
    chk(!rd_valid, "R7 valid low on underflow", {8'b0, rd_valid}, 9'h0);
    repeat (3) @(negedge rd_clk);
    chk(rd_empty && !rd_valid, "R7 underflow sticky", {7'b0, rd_empty, rd_valid}, 9'h2);

    // reset recovers
    rst_n = 0;
    repeat (2) @(negedge rd_clk);
    chk(!rd_empty && !wr_full, "R8 reset clears sticky flags", {7'b0, rd_empty, wr_full}, 9'h0);

    summary();
    $finish;
  end
endmodule